// File: doc/BRIEF.md
# Stream/Bus Mode Arbiter

This block decides which of two serial personalities a dual-mode configuration memory presents. At power-up it enables the clock-driven stream transmitter, which shifts the array out continuously on the stream clock. A falling edge on the bus clock moves it into a tentative state. In that state the I2C front end listens for the device's own control byte, and the block counts stream-clock pulses.

If the front end reports a matching control byte first, the block commits to the bidirectional bus personality. It stays there until reset. If 128 stream-clock pulses pass with the bus clock idle high, the tentative state is abandoned. The block then re-enables the stream transmitter and pulses a restart so that the stream begins again at the first bit of location zero.

The inputs are assumed to be already synchronised to the system clock. The mode is exposed as a 2-bit code alongside one-hot style enables.

Top module: `mode_switch_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `mode_o` is 2'b00 (stream), `stream_en_o` is 1, `bus_en_o` is 0 and `restart_o` is 0.
- R2: In stream mode (2'b00), stream-clock pulses and `ctrl_match_i` pulses have no effect while `scl_i` stays high.
- R3: A high-to-low change of `scl_i` in stream mode moves `mode_o` to 2'b01 (tentative) on the next clock edge, with `stream_en_o` 0 and `bus_en_o` 1; stream mode never goes straight to 2'b10.
- R4: In tentative mode each rising edge of `vclk_i` is counted. Once 128 are counted and `scl_i` is high, the block returns to mode 2'b00 one edge later; 127 pulses leave it in 2'b01.
- R5: Every falling edge of `scl_i` while in tentative mode clears the pulse count to zero.
- R6: `restart_o` is high for exactly one cycle, in the cycle the mode first reads 2'b00 after leaving 2'b01, and is low at all other times.
- R7: A `ctrl_match_i` pulse in tentative mode moves `mode_o` to 2'b10 (bus), with `bus_en_o` 1 and `stream_en_o` 0. If the match arrives in the same cycle as the pulse limit, the match wins and no restart is issued.
- R8: Mode 2'b10 is never left; only reset returns the block to 2'b00.
- R9: The pulse count is 8 bits wide and saturates at 255. When `scl_i` is held low through more than 255 pulses and then released high, the block returns to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | Synchronised bus clock level |
| vclk_i | input | 1 | Synchronised stream clock level |
| ctrl_match_i | input | 1 | One-cycle pulse: own control byte recognised |
| stream_en_o | output | 1 | Enables the stream transmitter |
| bus_en_o | output | 1 | Enables the I2C engine |
| restart_o | output | 1 | One-cycle pulse: restart stream at location zero, MSB |
| mode_o | output | 2 | 00 stream, 01 tentative, 10 bus |

## Verification
The critical collision is a control-byte match landing in the same cycle that the pulse count reaches its limit. The bench delivers 127 pulses and then a 128th. It raises the match pulse exactly when the count has become 128, so both decisions fall on one edge. The result must be bus mode with no restart pulse. A second overlap, a bus-clock fall together with an uncleared high count, is provoked by holding the bus clock low well past 255 pulses. Fallback must then wait for the clock to return high, and saturation must prevent a wrapped count from hiding the limit.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [1:0] {
    MODE_STREAM = 2'b00,
    MODE_TENT   = 2'b01,
    MODE_BUS    = 2'b10
  } mode_t;
endpackage

// File: rtl/msc_edge.sv
module msc_edge #(
  parameter bit FALLING = 1'b0,
  parameter bit RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_LVL;
    else     prev_q <= lvl_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~lvl_i;
    end else begin : g_rise
      assign edge_o = ~prev_q & lvl_i;
    end
  endgenerate
endmodule

// File: rtl/msc_pulse_cnt.sv
module msc_pulse_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/msc_mode_fsm.sv
module msc_mode_fsm
  import msc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  scl_lvl_i,
  input  logic  scl_fall_i,
  input  logic  match_i,
  input  logic  limit_i,
  output mode_t mode_o,
  output logic  stream_en_o,
  output logic  bus_en_o,
  output logic  restart_o
);
  mode_t state_q, state_d;
  logic  restart_d;

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    unique case (state_q)
      MODE_STREAM: if (scl_fall_i) state_d = MODE_TENT;
      MODE_TENT: begin
        if (match_i) begin
          state_d = MODE_BUS;
        end else if (limit_i && scl_lvl_i) begin
          state_d   = MODE_STREAM;
          restart_d = 1'b1;
        end
      end
      MODE_BUS: state_d = MODE_BUS;
      default:  state_d = MODE_STREAM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= MODE_STREAM;
      stream_en_o <= 1'b1;
      bus_en_o    <= 1'b0;
      restart_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      stream_en_o <= (state_d == MODE_STREAM);
      bus_en_o    <= (state_d != MODE_STREAM);
      restart_o   <= restart_d;
    end
  end

  assign mode_o = state_q;
endmodule

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl
  import msc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int IDLE_PULSES = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       vclk_i,
  input  logic       ctrl_match_i,
  output logic       stream_en_o,
  output logic       bus_en_o,
  output logic       restart_o,
  output logic [1:0] mode_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_PULSES);

  logic             scl_fall, vclk_rise, cnt_clr, limit_hit;
  logic [CNT_W-1:0] pulse_cnt;
  mode_t            mode;

  msc_edge #(.FALLING(1'b1), .RST_LVL(1'b1)) u_scl_edge (
    .clk(clk), .rst(rst), .lvl_i(scl_i), .edge_o(scl_fall));

  msc_edge #(.FALLING(1'b0), .RST_LVL(1'b1)) u_vclk_edge (
    .clk(clk), .rst(rst), .lvl_i(vclk_i), .edge_o(vclk_rise));

  assign cnt_clr = scl_fall || (mode != MODE_TENT);

  msc_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(vclk_rise), .cnt_o(pulse_cnt));

  assign limit_hit = (pulse_cnt >= LIMIT);

  msc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .scl_lvl_i(scl_i), .scl_fall_i(scl_fall),
    .match_i(ctrl_match_i), .limit_i(limit_hit), .mode_o(mode),
    .stream_en_o(stream_en_o), .bus_en_o(bus_en_o), .restart_o(restart_o));

  assign mode_o = mode;
endmodule

// File: rtl/mode_switch_chk.sv
module mode_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic       stream_en_o,
  input logic       bus_en_o,
  input logic       restart_o,
  input logic [1:0] mode_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (mode_o == 2'b00 && stream_en_o && !bus_en_o && !restart_o));

  assert_one_enable_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({stream_en_o, bus_en_o}) == 1);

  assert_no_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00) |=> (mode_o != 2'b10));

  assert_restart_single_R6: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);

  assert_restart_origin_R6: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> (mode_o == 2'b00 && $past(mode_o) == 2'b01));

  assert_bus_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b10) |=> (mode_o == 2'b10));
endmodule

bind mode_switch_ctrl mode_switch_chk u_chk (
  .clk(clk), .rst(rst), .stream_en_o(stream_en_o), .bus_en_o(bus_en_o),
  .restart_o(restart_o), .mode_o(mode_o));

// File: tb/mode_switch_ctrl_test.sv
`timescale 1ns/1ps
module mode_switch_ctrl_test;
  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, vclk = 1'b0, match = 1'b0;
  logic stream_en, bus_en, restart;
  logic [1:0] mode;
  int vectors = 0, miscompares = 0;

  mode_switch_ctrl uut (
    .clk(clk), .rst(rst), .scl_i(scl), .vclk_i(vclk), .ctrl_match_i(match),
    .stream_en_o(stream_en), .bus_en_o(bus_en), .restart_o(restart), .mode_o(mode));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; scl = 1'b1; vclk = 1'b0; match = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic vpulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) vclk = 1'b1;
      @(negedge clk) vclk = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic scl_dip();
    @(negedge clk) scl = 1'b0;
    @(negedge clk) scl = 1'b1;
    @(negedge clk);
  endtask

  task automatic match_pulse();
    @(negedge clk) match = 1'b1;
    @(negedge clk) match = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_R1();
    do_reset();
    check("R1 mode", mode, 0);
    check("R1 stream_en", stream_en, 1);
    check("R1 bus_en", bus_en, 0);
    check("R1 restart", restart, 0);
  endtask

  task automatic t_hold_R2();
    do_reset();
    vpulse(300);
    match_pulse();
    check("R2 mode after pulses+match", mode, 0);
    check("R2 stream_en", stream_en, 1);
    check("R2 restart", restart, 0);
  endtask

  task automatic t_enter_R3();
    do_reset();
    scl_dip();
    check("R3 mode tentative", mode, 1);
    check("R3 stream_en", stream_en, 0);
    check("R3 bus_en", bus_en, 1);
  endtask

  task automatic t_timeout_R4_R6();
    do_reset();
    scl_dip();
    vpulse(127);
    check("R4 127 pulses still tentative", mode, 1);
    vpulse(1);
    check("R4 128th pulse back to stream", mode, 0);
    check("R6 restart high", restart, 1);
    check("R4 stream_en", stream_en, 1);
    @(negedge clk);
    check("R6 restart one cycle", restart, 0);
  endtask

  task automatic t_clear_R5();
    do_reset();
    scl_dip();
    vpulse(100);
    scl_dip();
    vpulse(127);
    check("R5 count cleared by scl fall", mode, 1);
    vpulse(1);
    check("R5 limit after clear", mode, 0);
  endtask

  task automatic t_match_R7_R8();
    do_reset();
    scl_dip();
    vpulse(50);
    match_pulse();
    check("R7 bus mode", mode, 2);
    check("R7 bus_en", bus_en, 1);
    check("R7 stream_en", stream_en, 0);
    scl_dip();
    vpulse(200);
    match_pulse();
    check("R8 bus mode locked", mode, 2);
    check("R8 no restart", restart, 0);
    do_reset();
    check("R8 reset returns stream", mode, 0);
  endtask

  task automatic t_race_R7();
    do_reset();
    scl_dip();
    vpulse(127);
    @(negedge clk) vclk = 1'b1;
    @(negedge clk) begin vclk = 1'b0; match = 1'b1; end
    @(negedge clk) match = 1'b0;
    check("R7 match wins over limit", mode, 2);
    check("R7 R6 no restart on match", restart, 0);
  endtask

  task automatic t_saturate_R9();
    do_reset();
    @(negedge clk) scl = 1'b0;
    @(negedge clk);
    vpulse(300);
    check("R9 scl low holds tentative", mode, 1);
    @(negedge clk) scl = 1'b1;
    @(negedge clk);
    check("R9 saturated count returns", mode, 0);
    check("R9 restart", restart, 1);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset_R1();
    t_hold_R2();
    t_enter_R3();
    t_timeout_R4_R6();
    t_clear_R5();
    t_match_R7_R8();
    t_race_R7();
    t_saturate_R9();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule